// File: doc/BRIEF.md
# Video Control/Status Interrupt Registers

This block is the small register bank that sits beside a frame-buffer controller and lets software arm and service a once-per-frame interrupt. A byte-wide bus reaches a 32-byte window. The lower sixteen bytes belong to a neighbouring palette port and read back as zero here. The upper sixteen bytes hold an interrupt-enable control byte, a status byte and fourteen general storage bytes. Software uses the storage bytes for cursor limits and video-timing settings.

The vertical-sync input comes from the timing generator, and a rising edge on it marks the end of a frame. If the enable bit of the control byte is set at that edge, a sticky pending flag is set. The interrupt output follows that flag as a level. Software reads the status byte and sees the pending flag in bit 7, OR-ed with fixed board identification bits. Writing any value to the status byte clears the flag.

Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `vcsr_top`

## Requirements
- R1: After synchronous reset, irq_o is 0, the control byte (offset 0x10) reads 0x00, the status byte (0x11) reads 0x61, and every byte at 0x12..0x1F reads 0x00.
- R2: A write to offset 0x10 stores all eight bits, and a read of 0x10 returns them unchanged.
- R3: A read of offset 0x11 returns 0x61 when no interrupt is pending and 0xE1 when one is pending (bit 7 = pending, bits 6:5 = 2'b11 monitor code, bit 0 = 1 colour board).
- R4: A rising edge of vsync_i sampled while control bit 7 is 1 sets the pending flag at that clock edge.
- R5: A rising edge of vsync_i sampled while control bit 7 is 0 does not set the pending flag, and setting the enable bit later does not raise it for that past edge.
- R6: vsync_i held high across several clocks counts as one event. Once the flag is cleared, it stays clear until vsync_i goes low and rises again.
- R7: A write of any data value to offset 0x11 clears the pending flag at that edge.
- R8: The pending flag stays set until a status write, even if control bit 7 is cleared in the meantime.
- R9: If an enabled vsync rising edge and a status write fall on the same clock, the flag ends up set.
- R10: Offsets 0x12..0x1F are fourteen independent read/write bytes. A write to one leaves the others unchanged.
- R11: Reads of offsets 0x00..0x0F return 0x00. Writes to them change no register in the block.
- R12: irq_o always equals the pending flag, which is bit 7 of the status read.
- R13: A status write changes nothing in the status read except clearing bit 7. The identification bits stay 0x61.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset within the 32-byte window |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| vsync_i | input | 1 | Vertical sync from the timing generator; the rising edge is the event |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a status write that lands on the same clock as an enabled vsync rising edge. The bench drives vsync_i low, arms the enable bit, and then raises vsync_i in exactly the cycle that carries the status write. It then confirms that the flag is still set. A related case is a vsync level held high through a clear. The bench holds vsync_i high for several cycles, clears the flag in the middle of that stretch, and confirms that it stays clear until a fresh low-to-high transition. The reference model is compared on every clock, so a spurious re-trigger shows up at once.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int WIN_BYTES = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] OFS_STAT   = ADDR_W'(17);
    localparam logic [ADDR_W-1:0] OFS_GEN_LO = ADDR_W'(18);

    localparam int GEN_CNT   = WIN_BYTES - int'(OFS_GEN_LO);
    localparam int GEN_IDX_W = $clog2(GEN_CNT);

    localparam int IRQ_EN_BIT = 7;
    localparam int PEND_BIT   = 7;
    localparam logic [DATA_W-1:0] STAT_ID = DATA_W'(8'h61);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_GEN
    } sel_e;

    typedef struct packed {
        sel_e                 sel;
        logic [GEN_IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a == OFS_CTRL) begin
            d.sel = SEL_CTRL;
        end else if (a == OFS_STAT) begin
            d.sel = SEL_STAT;
        end else if (a >= OFS_GEN_LO) begin
            d.sel = SEL_GEN;
            d.idx = GEN_IDX_W'(a - OFS_GEN_LO);
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] status_view(input logic pend);
        logic [DATA_W-1:0] v;
        v = STAT_ID;
        v[PEND_BIT] = pend;
        return v;
    endfunction
endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
    import vcsr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    assign dec_o = decode_addr(addr_i);
endmodule

// File: rtl/vcsr_irq.sv
module vcsr_irq (
    input  logic clk,
    input  logic rst,
    input  logic vsync_i,
    input  logic irq_en_i,
    input  logic clr_i,
    output logic pend_o
);
    logic vs_q;
    logic pend_q;
    logic rise;

    assign rise = vsync_i & ~vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            if (rise && irq_en_i) begin
                pend_q <= 1'b1;
            end else if (clr_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/vcsr_store.sv
module vcsr_store
    import vcsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [GEN_IDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o
);
    logic [GEN_CNT-1:0][DATA_W-1:0] slot;

    for (genvar g = 0; g < GEN_CNT; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we_i && (idx_i == GEN_IDX_W'(g))) begin
                q <= wdata_i;
            end
        end
        assign slot[g] = q;
    end

    always_comb begin
        rdata_o = '0;
        if (int'(idx_i) < GEN_CNT) begin
            rdata_o = slot[idx_i];
        end
    end
endmodule

// File: rtl/vcsr_top.sv
module vcsr_top
    import vcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              vsync_i,
    output logic              irq_o
);
    dec_t              dec;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] gen_rd;
    logic              pend;
    logic              stat_clr;
    logic              gen_we;

    vcsr_decode u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && dec.sel == SEL_CTRL) begin
            ctrl_q <= bus_wdata;
        end
    end

    assign stat_clr = bus_wr && (dec.sel == SEL_STAT);
    assign gen_we   = bus_wr && (dec.sel == SEL_GEN);

    vcsr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .vsync_i  (vsync_i),
        .irq_en_i (ctrl_q[IRQ_EN_BIT]),
        .clr_i    (stat_clr),
        .pend_o   (pend)
    );

    vcsr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (gen_we),
        .idx_i   (dec.idx),
        .wdata_i (bus_wdata),
        .rdata_o (gen_rd)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_STAT: bus_rdata = status_view(pend);
            SEL_GEN:  bus_rdata = gen_rd;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = pend;
endmodule

// File: rtl/vcsr_top_chk.sv
module vcsr_top_chk
    import vcsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              vsync_i,
    input logic              irq_o,
    input logic              ctrl_en
);
    logic vs_d;
    logic ev;
    logic st_wr;

    always_ff @(posedge clk) begin
        if (rst) vs_d <= 1'b0;
        else     vs_d <= vsync_i;
    end

    assign ev    = vsync_i && !vs_d && ctrl_en;
    assign st_wr = bus_wr && (bus_addr == OFS_STAT);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq_o);
    p_stat_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STAT) |-> (bus_rdata == {irq_o, 7'h61}));
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        ev |=> irq_o);
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!irq_o && !ev) |=> !irq_o);
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_o && st_wr && !ev) |=> !irq_o);
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !st_wr) |=> irq_o);
    p_hole_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr < OFS_CTRL) |-> (bus_rdata == '0));
endmodule

bind vcsr_top vcsr_top_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .vsync_i   (vsync_i),
    .irq_o     (irq_o),
    .ctrl_en   (ctrl_q[7])
);

// File: tb/vcsr_top_test.sv
module vcsr_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       vsync_i = 1'b0;
    logic       irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_ctrl = 0;
    int m_pend = 0;
    int m_prev = 0;
    int m_gen[14];

    always #4 clk = ~clk;

    vcsr_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vsync_i(vsync_i), .irq_o(irq_o)
    );

    function automatic int exp_read(int a);
        if (a < 16)       return 0;
        else if (a == 16) return m_ctrl;
        else if (a == 17) return 8'h61 | (m_pend << 7);
        else              return m_gen[a-18];
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 0; m_pend = 0; m_prev = 0;
        for (int i = 0; i < 14; i++) m_gen[i] = 0;
    endtask

    // One bus cycle: drive, compare combinational outputs, then advance model at the edge
    task automatic step(int a, bit wr, int wd, bit vs, string tag);
        int rise;
        @(negedge clk);
        bus_addr = 5'(a); bus_wr = wr; bus_wdata = 8'(wd); vsync_i = vs;
        #1;
        check(tag, int'(bus_rdata), exp_read(a));
        check("R12", int'(irq_o), m_pend);
        @(posedge clk);
        rise = (vs && !m_prev) ? 1 : 0;
        if (rise && m_ctrl[7]) m_pend = 1;
        else if (wr && a == 17) m_pend = 0;
        if (wr && a == 16) m_ctrl = wd & 8'hFF;
        if (wr && a >= 18) m_gen[a-18] = wd & 8'hFF;
        m_prev = vs;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values across the whole mapped window
        for (int a = 16; a < 32; a++) step(a, 0, 0, 0, "R1");

        // R2: control byte full readback
        step(16, 1, 8'hA5, 0, "R2");
        step(16, 0, 0, 0, "R2");
        step(16, 1, 8'h00, 0, "R2");
        step(16, 0, 0, 0, "R2");

        // R5: vsync edge while disabled, then enable afterwards
        step(17, 0, 0, 1, "R5");
        step(17, 0, 0, 0, "R5");
        step(16, 1, 8'h80, 0, "R5");
        step(17, 0, 0, 0, "R5");

        // R4 and R3: enabled edge sets pending, status reads 0xE1
        step(17, 0, 0, 1, "R4");
        step(17, 0, 0, 1, "R3");
        // R6: held high, clear mid-pulse, must not re-trigger
        step(17, 1, 8'h00, 1, "R7");
        step(17, 0, 0, 1, "R6");
        step(17, 0, 0, 1, "R6");
        step(17, 0, 0, 0, "R6");
        step(17, 0, 0, 1, "R6");
        step(17, 0, 0, 0, "R3");

        // R8: pending survives disabling
        step(16, 1, 8'h00, 0, "R8");
        step(17, 0, 0, 0, "R8");
        step(17, 0, 0, 0, "R8");
        step(17, 1, 8'h5A, 0, "R7");
        step(17, 0, 0, 0, "R7");

        // R9: same-cycle event and clear
        step(16, 1, 8'h80, 0, "R9");
        step(17, 1, 8'hFF, 1, "R9");
        step(17, 0, 0, 0, "R9");
        step(17, 1, 8'h33, 0, "R7");

        // R13: status write with nothing pending keeps ID bits
        step(17, 1, 8'hFF, 0, "R13");
        step(17, 0, 0, 0, "R13");

        // R10: general bytes, distinct pattern each, then read all
        for (int a = 18; a < 32; a++) step(a, 1, (a * 37 + 11) & 8'hFF, 0, "R10");
        for (int a = 18; a < 32; a++) step(a, 0, 0, 0, "R10");
        step(25, 1, 8'hC3, 0, "R10");
        for (int a = 18; a < 32; a++) step(a, 0, 0, 0, "R10");

        // R11: lower half reads zero and writes touch nothing
        for (int a = 0; a < 16; a++) step(a, 1, 8'hFF, 0, "R11");
        for (int a = 0; a < 32; a++) step(a, 0, 0, 0, "R11");

        // R1: reset again after activity
        step(17, 0, 0, 1, "R4");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        for (int a = 16; a < 32; a++) step(a, 0, 0, 0, "R1");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule